// File: doc/BRIEF.md
# DMA channel start, count and completion control

This block is the control and status logic for a single DMA channel. Software writes a channel enable, a request mode and a transfer count through a small register port. The block combines these with a global master enable and two abort indications (a non-maskable interrupt flag and an address-error flag). Whenever a transfer is permitted, it issues one transfer strobe per clock to the datapath. In auto mode a strobe goes out in every permitted cycle. In external mode a strobe goes out only in permitted cycles where the request input is high.

Each strobe takes one off the count. The strobe that takes the count from one to zero is the last one, and it sets a completion flag. An abort or a disable stops the strobes, leaves the count where it was and never sets the flag. Software clears the flag only by writing zero to it after it has read it as one. While the flag is set, no transfer can start, even if the channel enable is set.

Register map: address 0 is control/status, with bit 0 the channel enable, bit 1 the completion flag and bit 2 the mode (1 = external request). Address 1 holds the transfer count.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset the channel enable, completion flag and mode read as 0, the count reads 0, and no strobe is issued.
- R2: A strobe is issued only when all of these hold: channel enable is 1, master enable is 1, the completion flag is 0, the abort flags are 0 and the count is nonzero.
- R3: In auto mode (address 0 bit 2 = 0), a strobe is issued in every permitted cycle. In external mode (bit 2 = 1), a strobe is issued only in permitted cycles where ext_req is 1.
- R4: Each strobe decrements the count by exactly one on the next clock edge. Strobes stop once the count is 0. A write to address 1 loads the count, and the write takes priority over a decrement in the same cycle.
- R5: The strobe that takes the count from 1 to 0 sets the completion flag (address 0 bit 1) on the same clock edge.
- R6: A high nmi_flag or addr_err stops strobes at once. The count holds its value and the completion flag stays 0.
- R7: Clearing the channel enable, or dropping master_en, stops strobes. The count holds and the completion flag stays 0.
- R8: The completion flag is cleared only by a write to address 0 with bit 1 = 0, made by a bus master that read address 0 while the flag was 1 after the flag was last set. A write of 1, and a write of 0 by a master with no such read, leave the flag set.
- R9: While the completion flag is 1, setting the channel enable produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Global DMA master enable |
| nmi_flag | input | 1 | Non-maskable interrupt abort flag |
| addr_err | input | 1 | Address-error abort flag |
| ext_req | input | 1 | External or peripheral transfer request |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register select: 0 control/status, 1 count |
| bus_master | input | MID_W | Identifier of the accessing bus master |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for the selected register |
| xfer_stb | output | 1 | One-cycle transfer strobe |
| xfer_done | output | 1 | Completion flag |

## Verification
The embedded assertions are checked on every cycle. They confirm that a strobe never appears unless every enable and abort condition permits it. They also confirm that the count moves only by a single decrement on a strobe or by a software load, that the flag rises only on the final strobe, and that the flag falls only on a write of zero. Some behaviour is visible only in the bench scenarios: whether the right master earned the right to clear the flag, the exact strobe pattern under a given request sequence, and the frozen count after each kind of abort. The bench follows these against a behavioural model on every clock.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl #(
  parameter int CNT_W       = 16,
  parameter int NUM_MASTERS = 2,
  parameter int MID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             nmi_flag,
  input  logic             addr_err,
  input  logic             ext_req,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_addr,
  input  logic [MID_W-1:0] bus_master,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             xfer_stb,
  output logic             xfer_done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             chan_en, ext_mode, done;
  logic [CNT_W-1:0] count;
  logic [NUM_MASTERS-1:0] seen;

  logic permit, set_done, read_one, clr_ok, wr_ctl, wr_cnt;

  assign permit   = chan_en & master_en & ~done & ~nmi_flag & ~addr_err & (count != '0);
  assign xfer_stb = permit & (~ext_mode | ext_req);
  assign set_done = xfer_stb & (count == ONE);
  assign wr_ctl   = bus_wr & ~bus_addr;
  assign wr_cnt   = bus_wr & bus_addr;
  assign read_one = bus_rd & ~bus_addr & done;
  assign clr_ok   = wr_ctl & ~bus_wdata[1] & done & seen[bus_master];
  assign xfer_done = done;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr) bus_rdata = count;
    else          bus_rdata[2:0] = {ext_mode, done, chan_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en  <= 1'b0;
      ext_mode <= 1'b0;
    end else if (wr_ctl) begin
      chan_en  <= bus_wdata[0];
      ext_mode <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (wr_cnt)   count <= bus_wdata;
    else if (xfer_stb) count <= count - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done <= 1'b0;
    else if (set_done) done <= 1'b1;
    else if (clr_ok)   done <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   seen <= '0;
    else if (set_done || clr_ok)  seen <= '0;
    else if (read_one)            seen[bus_master] <= 1'b1;
  end

  // R2
  stb_permitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |-> (master_en && !nmi_flag && !addr_err && !xfer_done && bus_rdata_en_ok()));

  function automatic logic bus_rdata_en_ok();
    return chan_en && (count != '0);
  endfunction

  // R4
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && !wr_cnt) |=> (count == $past(count) - ONE));

  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_stb && !wr_cnt) |=> $stable(count));

  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(xfer_stb && count == ONE));

  // R8
  done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(bus_wr && !bus_addr && !bus_wdata[1]));

  // R9
  done_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !xfer_stb);
endmodule

// File: tb/dma_chan_ctl_tb.sv
`timescale 1ns/1ps
module dma_chan_ctl_tb;
  localparam int CNT_W = 16;
  localparam int NM    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 0, nmi_flag = 0, addr_err = 0, ext_req = 0;
  logic bus_wr = 0, bus_rd = 0, bus_addr = 0;
  logic [0:0] bus_master = '0;
  logic [CNT_W-1:0] bus_wdata = '0;
  logic [CNT_W-1:0] bus_rdata;
  logic xfer_stb, xfer_done;

  int checks = 0, errors = 0, stb_seen = 0;

  dma_chan_ctl #(.CNT_W(CNT_W), .NUM_MASTERS(NM)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .nmi_flag(nmi_flag),
    .addr_err(addr_err), .ext_req(ext_req), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_master(bus_master), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .xfer_stb(xfer_stb), .xfer_done(xfer_done));

  always #2.5 clk = ~clk;

  // behavioural reference state
  bit m_en, m_mode, m_done;
  int m_cnt;
  bit m_seen[NM];

  function automatic bit m_stb();
    return m_en && master_en && !m_done && !nmi_flag && !addr_err && m_cnt != 0
           && (!m_mode || ext_req);
  endfunction

  function automatic int m_rdata();
    return bus_addr ? m_cnt : (int'(m_mode) << 2) | (int'(m_done) << 1) | int'(m_en);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_update();
    bit s, sd, clr, rone;
    s    = m_stb();
    sd   = s && m_cnt == 1;
    rone = bus_rd && !bus_addr && m_done;
    clr  = bus_wr && !bus_addr && !bus_wdata[1] && m_done && m_seen[bus_master];
    if (bus_wr && !bus_addr) begin m_en = bus_wdata[0]; m_mode = bus_wdata[2]; end
    if (bus_wr && bus_addr) m_cnt = bus_wdata;
    else if (s) m_cnt = m_cnt - 1;
    if (sd) m_done = 1; else if (clr) m_done = 0;
    if (sd || clr) foreach (m_seen[i]) m_seen[i] = 0;
    else if (rone) m_seen[bus_master] = 1;
  endtask

  task automatic tick();
    #1;
    check(xfer_stb == m_stb(), "R2", xfer_stb, m_stb());
    check(xfer_done == m_done, "R5", xfer_done, m_done);
    check(int'(bus_rdata) == m_rdata(), "R4", bus_rdata, m_rdata());
    if (xfer_stb) stb_seen++;
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input bit a, input int d, input int m = 0);
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = CNT_W'(d); bus_master = 1'(m);
    tick(); idle();
  endtask

  task automatic rd(input bit a, input int m, output int v);
    bus_rd = 1; bus_wr = 0; bus_addr = a; bus_master = 1'(m);
    #1 v = bus_rdata;
    tick(); idle();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  int v;

  initial begin
    #10000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_en = 0; m_mode = 0; m_done = 0; m_cnt = 0;
    foreach (m_seen[i]) m_seen[i] = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 0, v); check(v == 0, "R1", v, 0);
    rd(1, 0, v); check(v == 0, "R1", v, 0);
    check(!xfer_stb, "R1", xfer_stb, 0);

    // R2 master enable off blocks
    wr(1, 3); wr(0, 1); stb_seen = 0; run(4);
    check(stb_seen == 0, "R2", stb_seen, 0);

    // R3 auto mode run, R4 count, R5 done
    master_en = 1; stb_seen = 0; run(6);
    check(stb_seen == 3, "R3", stb_seen, 3);
    rd(1, 0, v); check(v == 0, "R4", v, 0);
    check(xfer_done, "R5", xfer_done, 1);

    // R8 write 1 and unread write 0 do not clear
    wr(0, 3); check(xfer_done, "R8", xfer_done, 1);
    wr(0, 1); check(xfer_done, "R8", xfer_done, 1);
    // R9 enable with count while done set
    wr(1, 5); wr(0, 1); stb_seen = 0; run(3);
    check(stb_seen == 0, "R9", stb_seen, 0);
    // R8 read by master 1, write 0 by master 0
    rd(0, 1, v); wr(0, 0, 0); check(xfer_done, "R8", xfer_done, 1);
    // R8 master 0 read then write 0
    rd(0, 0, v); wr(0, 0, 0); check(!xfer_done, "R8", xfer_done, 0);

    // R3 external mode
    wr(1, 4); wr(0, 5); stb_seen = 0;
    ext_req = 0; run(2); ext_req = 1; tick(); ext_req = 0; run(2);
    ext_req = 1; run(2); ext_req = 0; run(2);
    check(stb_seen == 3, "R3", stb_seen, 3);
    rd(1, 0, v); check(v == 1, "R3", v, 1);
    ext_req = 1; run(2); ext_req = 0;
    check(xfer_done, "R5", xfer_done, 1);
    rd(0, 1, v); wr(0, 0, 1);

    // R6 nmi abort
    wr(1, 6); wr(0, 1); run(2); nmi_flag = 1; stb_seen = 0; run(3);
    check(stb_seen == 0, "R6", stb_seen, 0);
    rd(1, 0, v); check(v == 4, "R6", v, 4);
    check(!xfer_done, "R6", xfer_done, 0);
    nmi_flag = 0;
    // R6 address error
    wr(1, 5); run(1); addr_err = 1; run(3);
    rd(1, 0, v); check(v == 4, "R6", v, 4);
    check(!xfer_done, "R6", xfer_done, 0);
    addr_err = 0;

    // R7 channel enable clear
    wr(1, 6); run(2); wr(0, 0); stb_seen = 0; run(3);
    check(stb_seen == 0, "R7", stb_seen, 0);
    rd(1, 0, v); check(v == 3, "R7", v, 3);
    check(!xfer_done, "R7", xfer_done, 0);
    // R7 master enable drop
    wr(0, 1); master_en = 0; stb_seen = 0; run(3);
    check(stb_seen == 0, "R7", stb_seen, 0);
    check(!xfer_done, "R7", xfer_done, 0);
    master_en = 1; run(4);
    check(xfer_done, "R5", xfer_done, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule